// File: doc/BRIEF.md
# Outlier-Rejecting Burst Averaging Filter

The block reduces a burst of 12-bit sensor readings to a single filtered reading. A burst begins on a sample that carries the start marker, and its length is chosen by a 3-bit mode sampled with that first sample. Short modes take the plain mean of one or two samples. Longer modes drop exactly one largest and one smallest sample and average what is left. The burst lengths are chosen so that every divisor is a power of two, which means the division is a plain right shift.

The extremes are tracked while the samples are being added, so no sorting and no sample storage are needed. When the last sample of a burst is accepted, the result is registered and presented with a single-cycle done strobe on the next cycle. Samples may arrive with idle gaps between them. A new start marker always aborts any partial burst.

Top module: `avgf_filter`

## Requirements
- R1: After reset, done_o is 0 and result_o is 0.
- R2: Mode 0 uses one sample. result_o equals that sample, and done_o pulses on the following cycle.
- R3: Mode 1 takes two samples, and result_o is their sum shifted right by 1 (truncated).
- R4: Mode 2 takes four samples, removes one maximum and one minimum, and outputs the sum of the other two shifted right by 1. When values repeat, only one copy of the largest and one copy of the smallest are removed.
- R5: Mode 3 takes six samples, removes one maximum and one minimum, and outputs the remaining sum shifted right by 2.
- R6: Mode 4 takes ten samples, removes one maximum and one minimum, and outputs the remaining sum shifted right by 3. Full-scale input (4095) is reproduced exactly.
- R7: Mode 5 takes eighteen samples, removes one maximum and one minimum, and outputs the remaining sum shifted right by 4. The internal sum never overflows.
- R8: Mode values 6 and 7 behave exactly like mode 0.
- R9: A sample with start_i high that arrives during a burst discards the partial burst and becomes the first sample of a new burst.
- R10: A sample with sample_valid_i high and start_i low, arriving while no burst is open, is ignored and produces no done_o.
- R11: done_o is high for exactly one cycle, on the cycle after the last sample of a burst is accepted. It stays low while the burst is incomplete, including across cycles with sample_valid_i low.
- R12: The mode is captured with the first sample. Changes on mode_i later in the burst do not alter the burst length or the filtering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 12 | Sample value |
| sample_valid_i | input | 1 | sample_i is valid this cycle |
| start_i | input | 1 | The valid sample is the first of a new burst |
| mode_i | input | 3 | Burst mode, captured with the first sample |
| result_o | output | 12 | Filtered result of the last completed burst |
| done_o | output | 1 | One-cycle strobe: result_o has just been updated |

## Verification
The bench builds the block with its default 12-bit sample width and 18-sample maximum burst. This makes it possible to drive a full-scale burst that stresses the 17-bit accumulator, and to use the longest burst with a drop of both extremes. Each mode is run from a vector table, together with repeated values and a truncating sum. Directed sequences then cover restart mid-burst, stray samples while idle, gaps within a burst, mode changes after the first sample, and back-to-back single-sample bursts.

// File: rtl/avgf_pkg.sv
package avgf_pkg;
  localparam int unsigned MAX_BURST = 18;
  localparam int unsigned CNT_W     = $clog2(MAX_BURST + 1);
  localparam int unsigned SH_W      = 3;
  localparam int unsigned MODE_W    = 3;

  typedef struct packed {
    logic [CNT_W-1:0] n;      // samples in burst
    logic             drop;   // reject one max and one min
    logic [SH_W-1:0]  shift;  // log2 of divisor
  } burst_cfg_t;

  function automatic burst_cfg_t decode_mode(input logic [MODE_W-1:0] m);
    burst_cfg_t c;
    case (m)
      3'd1:    c = '{n: CNT_W'(2),  drop: 1'b0, shift: SH_W'(1)};
      3'd2:    c = '{n: CNT_W'(4),  drop: 1'b1, shift: SH_W'(1)};
      3'd3:    c = '{n: CNT_W'(6),  drop: 1'b1, shift: SH_W'(2)};
      3'd4:    c = '{n: CNT_W'(10), drop: 1'b1, shift: SH_W'(3)};
      3'd5:    c = '{n: CNT_W'(18), drop: 1'b1, shift: SH_W'(4)};
      default: c = '{n: CNT_W'(1),  drop: 1'b0, shift: SH_W'(0)};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/avgf_mode_decode.sv
module avgf_mode_decode
  import avgf_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output burst_cfg_t        cfg_o
);
  always_comb cfg_o = decode_mode(mode_i);

  always_comb begin
    AST_CFG_SANE: assert (cfg_o.n >= CNT_W'(1) && cfg_o.n <= CNT_W'(MAX_BURST)
                          && (!cfg_o.drop || (cfg_o.n == CNT_W'((1 << cfg_o.shift) + 2)))); // R7
  end
endmodule

// File: rtl/avgf_extreme_track.sv
module avgf_extreme_track #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              first_i,
  input  logic [DATA_W-1:0] smp_i,
  output logic [DATA_W-1:0] min_nxt_o,
  output logic [DATA_W-1:0] max_nxt_o
);
  logic [DATA_W-1:0] min_q, max_q;
  logic              seen_q;

  always_comb begin
    if (first_i) begin
      min_nxt_o = smp_i;
      max_nxt_o = smp_i;
    end else begin
      min_nxt_o = (smp_i < min_q) ? smp_i : min_q;
      max_nxt_o = (smp_i > max_q) ? smp_i : max_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_q  <= '0;
      max_q  <= '0;
      seen_q <= 1'b0;
    end else if (acc_i) begin
      min_q  <= min_nxt_o;
      max_q  <= max_nxt_o;
      seen_q <= 1'b1;
    end
  end

  AST_MIN_LE_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (min_q <= max_q)); // R4

  AST_NEW_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !first_i) |=> (min_q <= $past(smp_i) && max_q >= $past(smp_i))); // R4
endmodule

// File: rtl/avgf_accum.sv
module avgf_accum #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned ACC_W  = 17,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned MAX_N  = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              first_i,
  input  logic [DATA_W-1:0] smp_i,
  output logic [ACC_W-1:0]  sum_nxt_o,
  output logic [CNT_W-1:0]  cnt_nxt_o
);
  logic [ACC_W-1:0] sum_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    sum_nxt_o = (first_i ? '0 : sum_q) + ACC_W'(smp_i);
    cnt_nxt_o = (first_i ? '0 : cnt_q) + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (acc_i) begin
      sum_q <= sum_nxt_o;
      cnt_q <= cnt_nxt_o;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_N)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(sum_q) <= int'(cnt_q) * ((1 << DATA_W) - 1)); // R7

  AST_RESTART_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && first_i) |=> (cnt_q == CNT_W'(1))); // R9
endmodule

// File: rtl/avgf_filter.sv
module avgf_filter
  import avgf_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              sample_valid_i,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [DATA_W-1:0] result_o,
  output logic              done_o
);
  localparam int unsigned ACC_W = DATA_W + $clog2(MAX_BURST);

  burst_cfg_t        cfg_dec, cfg_q, cfg_cur;
  logic              active_q, first, acc, last;
  logic [ACC_W-1:0]  sum_nxt, trim;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [DATA_W-1:0] min_nxt, max_nxt, res_d;

  avgf_mode_decode u_dec (
    .mode_i (mode_i),
    .cfg_o  (cfg_dec)
  );

  assign first   = sample_valid_i && start_i;
  assign acc     = sample_valid_i && (start_i || active_q);
  assign cfg_cur = first ? cfg_dec : cfg_q;

  avgf_accum #(
    .DATA_W (DATA_W),
    .ACC_W  (ACC_W),
    .CNT_W  (CNT_W),
    .MAX_N  (MAX_BURST)
  ) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc),
    .first_i   (first),
    .smp_i     (sample_i),
    .sum_nxt_o (sum_nxt),
    .cnt_nxt_o (cnt_nxt)
  );

  avgf_extreme_track #(
    .DATA_W (DATA_W)
  ) u_ext (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc),
    .first_i   (first),
    .smp_i     (sample_i),
    .min_nxt_o (min_nxt),
    .max_nxt_o (max_nxt)
  );

  assign last = acc && (cnt_nxt == cfg_cur.n);

  always_comb begin
    trim  = cfg_cur.drop ? (sum_nxt - ACC_W'(min_nxt) - ACC_W'(max_nxt)) : sum_nxt;
    res_d = DATA_W'(trim >> cfg_cur.shift);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cfg_q    <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= last;
      if (first) cfg_q <= cfg_dec;
      if (acc)   active_q <= !last;
      if (last)  result_o <= res_d;
    end
  end

  AST_DONE_AFTER_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(sample_valid_i)); // R11

  AST_MODE0_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && start_i && mode_i == '0) |=> (done_o && result_o == $past(sample_i))); // R2

  AST_IDLE_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && sample_valid_i && !start_i) |=> !done_o); // R10

  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first && cfg_dec.n > CNT_W'(1)) |=> (active_q && !done_o)); // R9

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o)); // R11
endmodule

// File: tb/avgf_filter_bench.sv
`timescale 1ns/1ps
module avgf_filter_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] sample_i = '0;
  logic        sample_valid_i = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [11:0] result_o;
  logic        done_o;

  int checks = 0;
  int failures = 0;

  always #2 clk_i = ~clk_i;

  avgf_filter u_avgf_filter (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sample_i       (sample_i),
    .sample_valid_i (sample_valid_i),
    .start_i        (start_i),
    .mode_i         (mode_i),
    .result_o       (result_o),
    .done_o         (done_o)
  );

  localparam int NV = 10;
  localparam logic [2:0] VMODE [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7, 3'd2, 3'd1};
  localparam int         VN    [NV] = '{1, 2, 4, 6, 10, 18, 1, 1, 4, 2};
  localparam logic [11:0] VEXP [NV] = '{12'hABC, 12'd151, 12'd25, 12'd3, 12'd4095, 12'd8,
                                        12'd7, 12'd4000, 12'd5, 12'd0};
  localparam logic [11:0] VSMP [NV][18] = '{
    '{12'hABC, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0},
    '{100, 203, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0},
    '{10, 50, 20, 30, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0},
    '{1, 2, 3, 4, 5, 100, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0},
    '{4095, 4095, 4095, 4095, 4095, 4095, 4095, 4095, 4095, 4095, 0, 0, 0, 0, 0, 0, 0, 0},
    '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 14, 15, 16, 17},
    '{7, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0},
    '{4000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0},
    '{5, 5, 5, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0},
    '{0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one cycle at a negedge, return at the next negedge
  task automatic put(input logic [11:0] s, input logic st, input logic [2:0] m);
    sample_i = s; sample_valid_i = 1'b1; start_i = st; mode_i = m;
    @(negedge clk_i);
  endtask

  task automatic idle();
    sample_valid_i = 1'b0; start_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic run_vec(input int i);
    string tag;
    case (VMODE[i])
      3'd0: tag = "R2";
      3'd1: tag = "R3";
      3'd2: tag = "R4";
      3'd3: tag = "R5";
      3'd4: tag = "R6";
      3'd5: tag = "R7";
      default: tag = "R8";
    endcase
    for (int k = 0; k < VN[i]; k++) begin
      put(VSMP[i][k], k == 0, VMODE[i]);
      if (k < VN[i] - 1) check("R11 early done", done_o, 0);
    end
    check({tag, " done"}, done_o, 1);
    check({tag, " result"}, result_o, VEXP[i]);
    idle();
    check("R11 single pulse", done_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 done", done_o, 0);
    check("R1 result", result_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R10: stray samples while idle
    put(12'd999, 1'b0, 3'd0);
    check("R10 stray", done_o, 0);
    put(12'd998, 1'b0, 3'd1);
    check("R10 stray", done_o, 0);
    idle();
    check("R10 result kept", result_o, 0);

    // R9: restart mid-burst
    put(12'd4000, 1'b1, 3'd2);
    put(12'd4000, 1'b0, 3'd2);
    check("R9 partial", done_o, 0);
    put(12'd10, 1'b1, 3'd1);
    check("R9 restart", done_o, 0);
    put(12'd20, 1'b0, 3'd1);
    check("R9 done", done_o, 1);
    check("R9 result", result_o, 15);
    idle();

    // R11: gaps inside a burst
    put(12'd300, 1'b1, 3'd1);
    idle();
    check("R11 gap", done_o, 0);
    idle();
    check("R11 gap", done_o, 0);
    put(12'd101, 1'b0, 3'd1);
    check("R11 done after gap", done_o, 1);
    check("R11 result", result_o, 200);
    idle();

    // R12: mode change after first sample
    put(12'd8, 1'b1, 3'd2);
    put(12'd2, 1'b0, 3'd0);
    check("R12 no early end", done_o, 0);
    put(12'd6, 1'b0, 3'd5);
    check("R12 no early end", done_o, 0);
    put(12'd4, 1'b0, 3'd1);
    check("R12 done", done_o, 1);
    check("R12 result", result_o, 5);
    idle();

    // R2: back-to-back single-sample bursts
    put(12'd11, 1'b1, 3'd0);
    check("R2 b2b done", done_o, 1);
    check("R2 b2b result", result_o, 11);
    put(12'd22, 1'b1, 3'd7);
    check("R2 b2b done", done_o, 1);
    check("R8 b2b result", result_o, 22);
    idle();
    check("R11 pulse end", done_o, 0);

    // R1: reset mid-burst clears state
    put(12'd50, 1'b1, 3'd3);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 reset done", done_o, 0);
    check("R1 reset result", result_o, 0);
    rst_ni = 1'b1;
    put(12'd60, 1'b0, 3'd3);
    check("R1 no burst after reset", done_o, 0);
    idle();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule